// File: doc/BRIEF.md
# Strided SIMD Split-Transaction Memory Unit

This block sits between a group of four processing lanes and four interleaved memory banks. A requester issues a single request whose header holds a mode flag, a base address, a stride and a request tag. In vector mode the block expands that request into one access per lane, with lane `i` addressing `base + i*stride`. In scalar mode it issues a single access. The request is accepted in one cycle and the data comes back later as separate responses. Each response carries the tag and the lane number, so a consumer can steer every word to the lane that asked for it.

Accesses are spread over the banks by the low address bits. When several accesses fall on the same bank they wait in that bank's queue, and the bank serves them one per cycle. Each bank has its own response port. Responses from different banks can therefore appear in the same cycle, and they do not need to arrive in lane order. The request port refuses new work when a bank queue cannot take a full set of lane accesses.

Top module: `simd_stride_mem`

## Requirements
- R1: After reset every `rsp_valid` bit is 0, `req_ready` is 1, and every memory word reads as 0.
- R2: An accepted request with `req_simd`=1 makes four accesses. Lane i (0..3) uses address (base + i*stride) mod 256. The bank is address bits [1:0] and the row within the bank is bits [7:2].
- R3: Each access produces exactly one response, on the port of its bank (port b occupies bit b of `rsp_valid` and slice b of each packed response bus). The response carries the request tag and the lane index. A read returns the stored word. A write stores lane i's slice `req_wdata[16*i +: 16]` and returns that value.
- R4: An accepted request with `req_simd`=0 makes exactly one access, as lane 0, at the base address with lane 0's write data, and produces exactly one response.
- R5: A bank performs at most one access per cycle. Accesses to one bank are performed oldest first, and lanes of the same request are taken in ascending order. A later read therefore sees every earlier write to the same address.
- R6: Let a request be accepted at clock edge E. An access whose bank queue is empty before E has its response valid in the cycle after E. Each access queued ahead of it on the same bank delays it by one cycle. A response is valid for one cycle only.
- R7: `req_ready` is 1 exactly when every bank queue (depth 8) has at least four free entries. A request presented while `req_ready` is 0 is ignored: it makes no access and produces no response.
- R8: Responses from different banks may be valid in the same cycle and need not follow lane order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_simd | input | 1 | 1 = one access per lane, 0 = single access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_id | input | 4 | Request tag returned with every response |
| req_base | input | 8 | Base word address |
| req_stride | input | 8 | Address step between lanes |
| req_wdata | input | 64 | Write data, lane i in bits [16*i +: 16] |
| rsp_valid | output | 4 | One response valid bit per bank |
| rsp_id | output | 16 | Tag per bank port, 4 bits each |
| rsp_lane | output | 8 | Lane index per bank port, 2 bits each |
| rsp_data | output | 64 | Data per bank port, 16 bits each |

## Verification
Every response is due a fixed number of cycles after its request. An access to an idle bank answers in the cycle after the accepting edge. An access to a busy bank answers one cycle later for each access already queued on that bank. `req_ready` reflects the queue occupancy left by the most recent edge. The bench keeps a behavioural model made of per-bank queues and a flat word array, and advances it once per rising edge. It then compares every response port and the ready flag at the following falling edge, so each expected value is sampled in exactly the cycle in which it falls due. Stimulus covers:
- scalar and vector requests
- strides of 0, 1, 2, 3 and 4
- address wrap-around
- a bank queue kept busy so that later lanes overtake earlier ones
- requests held against backpressure

// File: rtl/simd_mem_pkg.sv
package simd_mem_pkg;
    parameter int LANES  = 4;
    parameter int NBANKS = 4;
    parameter int ADDR_W = 8;
    parameter int DW     = 16;
    parameter int ID_W   = 4;

    localparam int LANE_W = $clog2(LANES);
    localparam int BANK_W = $clog2(NBANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = 1 << ROW_W;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LANE_W-1:0] lane;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [DW-1:0]     wdata;
    } access_t;

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        access_t           acc;
    } lane_req_t;
endpackage

// File: rtl/lane_expand.sv
module lane_expand
    import simd_mem_pkg::*;
(
    input  logic                  simd_i,
    input  logic                  we_i,
    input  logic [ID_W-1:0]       id_i,
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [ADDR_W-1:0]     stride_i,
    input  logic [LANES*DW-1:0]   wdata_i,
    output lane_req_t             lanes_o [LANES]
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0] offset;
        logic [ADDR_W-1:0] addr;
        always_comb begin
            offset                 = stride_i * ADDR_W'(i);
            addr                   = base_i + offset;
            lanes_o[i].valid       = (i == 0) ? 1'b1 : simd_i;
            lanes_o[i].bank        = addr[BANK_W-1:0];
            lanes_o[i].acc.id      = id_i;
            lanes_o[i].acc.lane    = LANE_W'(i);
            lanes_o[i].acc.we      = we_i;
            lanes_o[i].acc.row     = addr[ADDR_W-1:BANK_W];
            lanes_o[i].acc.wdata   = wdata_i[i*DW +: DW];
        end
    end
endmodule

// File: rtl/bank_queue.sv
module bank_queue
    import simd_mem_pkg::*;
#(
    parameter int QDEPTH  = 8,
    parameter int BANK_ID = 0,
    localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en_i,
    input  lane_req_t       lanes_i [LANES],
    output logic            pop_o,
    output access_t         head_o,
    output logic            room_o,
    output logic [CNT_W-1:0] push_cnt_o
);
    typedef struct packed {
        access_t [QDEPTH-1:0] slot;
        logic [PTR_W-1:0]     rd;
        logic [PTR_W-1:0]     wr;
        logic [CNT_W-1:0]     cnt;
    } qstate_t;

    qstate_t s_d, s_q;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (int'(p) == QDEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        logic [PTR_W-1:0] idx;
        logic [CNT_W-1:0] n;
        s_d   = s_q;
        pop_o = (s_q.cnt != '0);
        if (pop_o) begin
            s_d.rd = step_ptr(s_q.rd);
        end
        idx = s_q.wr;
        n   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (push_en_i && lanes_i[l].valid && (int'(lanes_i[l].bank) == BANK_ID)) begin
                s_d.slot[idx] = lanes_i[l].acc;
                idx           = step_ptr(idx);
                n             = n + CNT_W'(1);
            end
        end
        s_d.wr     = idx;
        s_d.cnt    = s_q.cnt - CNT_W'(pop_o) + n;
        push_cnt_o = n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o = s_q.slot[s_q.rd];
    assign room_o = (int'(s_q.cnt) <= QDEPTH - LANES);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) <= QDEPTH);
    // R7
    push_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt_o != '0) |-> room_o);
    // R5
    serve_one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o && push_cnt_o == '0) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/bank_array.sv
module bank_array
    import simd_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_i,
    input  access_t           head_i,
    output logic              rsp_valid_o,
    output logic [ID_W-1:0]   rsp_id_o,
    output logic [LANE_W-1:0] rsp_lane_o,
    output logic [DW-1:0]     rsp_data_o
);
    typedef struct packed {
        logic [ROWS-1:0][DW-1:0] mem;
        logic                    valid;
        logic [ID_W-1:0]         id;
        logic [LANE_W-1:0]       lane;
        logic [DW-1:0]           data;
    } bstate_t;

    bstate_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = pop_i;
        if (pop_i) begin
            s_d.id   = head_i.id;
            s_d.lane = head_i.lane;
            if (head_i.we) begin
                s_d.mem[head_i.row] = head_i.wdata;
                s_d.data            = head_i.wdata;
            end else begin
                s_d.data = s_q.mem[head_i.row];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid_o = s_q.valid;
    assign rsp_id_o    = s_q.id;
    assign rsp_lane_o  = s_q.lane;
    assign rsp_data_o  = s_q.data;

    // R6
    rsp_after_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> rsp_valid_o);
    // R6
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> !rsp_valid_o);
    // R3
    write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && head_i.we) |=> (rsp_data_o == $past(head_i.wdata)));
endmodule

// File: rtl/simd_stride_mem.sv
module simd_stride_mem
    import simd_mem_pkg::*;
#(
    parameter int QDEPTH = 8,
    localparam int CNT_W = $clog2(QDEPTH + 1),
    localparam int SUM_W = $clog2(NBANKS * QDEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_simd,
    input  logic                     req_we,
    input  logic [ID_W-1:0]          req_id,
    input  logic [ADDR_W-1:0]        req_base,
    input  logic [ADDR_W-1:0]        req_stride,
    input  logic [LANES*DW-1:0]      req_wdata,
    output logic [NBANKS-1:0]        rsp_valid,
    output logic [NBANKS*ID_W-1:0]   rsp_id,
    output logic [NBANKS*LANE_W-1:0] rsp_lane,
    output logic [NBANKS*DW-1:0]     rsp_data
);
    lane_req_t        lanes [LANES];
    logic [NBANKS-1:0] room;
    logic [NBANKS-1:0] pop;
    access_t          head [NBANKS];
    logic [CNT_W-1:0] push_cnt [NBANKS];
    logic             accept;
    logic [SUM_W-1:0] push_total;

    assign req_ready = &room;
    assign accept    = req_valid && req_ready;

    lane_expand u_expand (
        .simd_i   (req_simd),
        .we_i     (req_we),
        .id_i     (req_id),
        .base_i   (req_base),
        .stride_i (req_stride),
        .wdata_i  (req_wdata),
        .lanes_o  (lanes)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        bank_queue #(.QDEPTH(QDEPTH), .BANK_ID(b)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_en_i  (accept),
            .lanes_i    (lanes),
            .pop_o      (pop[b]),
            .head_o     (head[b]),
            .room_o     (room[b]),
            .push_cnt_o (push_cnt[b])
        );
        bank_array u_array (
            .clk         (clk),
            .rst_n       (rst_n),
            .pop_i       (pop[b]),
            .head_i      (head[b]),
            .rsp_valid_o (rsp_valid[b]),
            .rsp_id_o    (rsp_id[b*ID_W +: ID_W]),
            .rsp_lane_o  (rsp_lane[b*LANE_W +: LANE_W]),
            .rsp_data_o  (rsp_data[b*DW +: DW])
        );
    end

    always_comb begin
        push_total = '0;
        for (int b = 0; b < NBANKS; b++) begin
            push_total = push_total + SUM_W'(push_cnt[b]);
        end
    end

    // R7
    refused_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (push_total == '0));
    // R2
    simd_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_simd) |-> (int'(push_total) == LANES));
    // R4
    scalar_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_simd) |-> (push_total == SUM_W'(1)));
endmodule

// File: tb/sim_simd_stride_mem.sv
module sim_simd_stride_mem;
    localparam int QD = 8;
    localparam int NB = 4;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_simd = 1'b0;
    logic        req_we = 1'b0;
    logic [3:0]  req_id = '0;
    logic [7:0]  req_base = '0;
    logic [7:0]  req_stride = '0;
    logic [63:0] req_wdata = '0;
    logic [3:0]  rsp_valid;
    logic [15:0] rsp_id;
    logic [7:0]  rsp_lane;
    logic [63:0] rsp_data;

    always #4 clk = ~clk;

    simd_stride_mem u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_simd(req_simd), .req_we(req_we), .req_id(req_id), .req_base(req_base),
        .req_stride(req_stride), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .rsp_lane(rsp_lane), .rsp_data(rsp_data)
    );

    typedef struct {
        int id;
        int lane;
        bit we;
        int addr;
        int data;
    } mref_t;

    mref_t q [NB][$];
    int    mem [256];
    int    exp_v [NB];
    int    exp_id [NB];
    int    exp_lane [NB];
    int    exp_data [NB];
    int    exp_ready = 1;
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    function automatic bit model_ready();
        for (int b = 0; b < NB; b++) if (q[b].size() > QD - NL) return 0;
        return 1;
    endfunction

    task automatic model_edge();
        bit rdy = model_ready();
        for (int b = 0; b < NB; b++) begin
            if (q[b].size() > 0) begin
                mref_t e = q[b].pop_front();
                if (e.we) mem[e.addr] = e.data;
                exp_v[b] = 1; exp_id[b] = e.id; exp_lane[b] = e.lane; exp_data[b] = mem[e.addr];
            end else begin
                exp_v[b] = 0;
            end
        end
        if (req_valid && rdy) begin
            int n = req_simd ? NL : 1;
            for (int l = 0; l < n; l++) begin
                mref_t e;
                e.addr = (int'(req_base) + l * int'(req_stride)) % 256;
                e.id = int'(req_id); e.lane = l; e.we = req_we;
                e.data = int'(req_wdata[l*16 +: 16]);
                q[e.addr % NB].push_back(e);
            end
        end
        exp_ready = model_ready();
    endtask

    task automatic compare();
        chk("req_ready", int'(req_ready), exp_ready);
        for (int b = 0; b < NB; b++) begin
            chk($sformatf("bank%0d valid", b), int'(rsp_valid[b]), exp_v[b]);
            if (exp_v[b] != 0 && rsp_valid[b]) begin
                chk($sformatf("bank%0d id", b), int'(rsp_id[b*4 +: 4]), exp_id[b]);
                chk($sformatf("bank%0d lane", b), int'(rsp_lane[b*2 +: 2]), exp_lane[b]);
                chk($sformatf("bank%0d data", b), int'(rsp_data[b*16 +: 16]), exp_data[b]);
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic setreq(bit simd, bit we, int id, int base, int stride,
                          int d0, int d1, int d2, int d3);
        req_valid = 1'b1; req_simd = simd; req_we = we; req_id = 4'(id);
        req_base = 8'(base); req_stride = 8'(stride);
        req_wdata = {16'(d3), 16'(d2), 16'(d1), 16'(d0)};
    endtask

    task automatic send(bit simd, bit we, int id, int base, int stride,
                        int d0, int d1, int d2, int d3);
        setreq(simd, we, id, base, stride, d0, d1, d2, d3);
        cyc();
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 0;
        for (int b = 0; b < NB; b++) exp_v[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        compare();
        idle(2);

        tag = "R4";   // scalar read of untouched word, then write and read back
        send(0, 0, 1, 5, 0, 0, 0, 0, 0);
        idle(2);
        send(0, 1, 2, 5, 7, 16'hA5A5, 16'h1111, 0, 0);
        send(0, 0, 3, 5, 0, 0, 0, 0, 0);
        idle(2);

        tag = "R6";   // stride 1: four banks, all answer in the next cycle
        send(1, 1, 4, 8, 1, 1, 2, 3, 4);
        idle(1);
        send(1, 0, 5, 8, 1, 0, 0, 0, 0);
        idle(2);

        tag = "R5";   // stride 4: one bank, lanes served in order
        send(1, 1, 6, 12, 4, 10, 20, 30, 40);
        send(1, 0, 7, 12, 4, 0, 0, 0, 0);
        idle(9);

        tag = "R2";   // wrap-around and stride 3
        send(1, 1, 8, 250, 3, 100, 200, 300, 400);
        send(1, 0, 9, 250, 3, 0, 0, 0, 0);
        idle(4);

        tag = "R3";   // stride 0: last lane's write wins, reads all see it
        send(1, 1, 10, 33, 0, 7, 8, 9, 11);
        send(1, 0, 11, 33, 0, 0, 0, 0, 0);
        idle(9);
        send(1, 0, 12, 0, 2, 0, 0, 0, 0);
        idle(3);

        tag = "R8";   // busy bank 0 lets later lanes overtake lane 0
        send(1, 0, 13, 0, 4, 0, 0, 0, 0);
        send(1, 0, 14, 16, 1, 0, 0, 0, 0);
        idle(7);

        tag = "R7";   // hold requests against backpressure
        setreq(1, 0, 15, 4, 4, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cyc();
        setreq(1, 1, 3, 40, 4, 5, 6, 7, 8);
        for (int i = 0; i < 6; i++) cyc();
        req_valid = 1'b0;
        idle(12);
        send(1, 0, 2, 40, 4, 0, 0, 0, 0);
        idle(6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule